// File: doc/BRIEF.md
# Shared-Bus Register Bank

A bank of equal-width registers that all sit on one common data bus. Every register has two control lines of its own: a store strobe and an output enable. While a register's store strobe is high, the register takes the resolved bus value on each clock edge. Once the strobe drops, the register keeps its last value, and later bus activity leaves it unchanged. While a register's output enable is high, its contents are placed on the bus. A disabled register places all zeros on the bus.

The bus is resolved as a wired-OR. Each bus bit is the OR of every register's gated contribution and of an optional external driver, which counts only while its valid flag is high. The main use is a copy from one register to another. Raise the source's enable, pulse the destination's store strobe, then drop the enable. The destination then holds the source's value and the bus returns to zero. The external driver is how values enter the bank in the first place.

The bus is a combinational output. A store on a clock edge captures the bus value present in the cycle that ends at that edge. Reset is synchronous and active-high, and it clears every register.

Top module: `shared_bus_regbank`

## Requirements
- R1: On a clock edge with `rst` high, every register becomes 0x00. After reset, enabling any single register with no external drive shows 0x00 on `bus_o`.
- R2: On a clock edge with `rst` low and `store_i[k]` high, register k takes the value `bus_o` had in the cycle ending at that edge.
- R3: On a clock edge with `store_i[k]` low, register k keeps its value, whatever the bus carries.
- R4: A register with `enable_i[k]` low contributes all zeros to the bus. With no enable high and `ext_valid_i` low, `bus_o` is 0x00.
- R5: Each bit of `bus_o` is the OR of the enabled registers' bits and, when `ext_valid_i` is high, of `ext_data_i`. One source driving a 0 never clears another source's 1.
- R6: A copy works in four steps: raise the source's enable, raise the destination's store strobe, drop that strobe, drop the source's enable. Afterwards the destination holds the source's value, the bus is 0x00, and the other registers are unchanged.
- R7: While `ext_valid_i` is low, `ext_data_i` has no effect on `bus_o` or on any register.
- R8: When several store strobes are high on one edge, every strobed register captures the same resolved bus value.
- R9: A register that is enabled and strobed on the same edge captures its own value OR-ed with the other contributions on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| store_i | input | NREG | Per-register store strobe, bit k for register k |
| enable_i | input | NREG | Per-register output enable, bit k for register k |
| ext_data_i | input | WIDTH | External bus driver value |
| ext_valid_i | input | 1 | External driver takes part in the bus when high |
| bus_o | output | WIDTH | Resolved wired-OR bus value, combinational |

## Verification
The bench goes after several corner cases, each paired with the failure it exposes.

- **Capture timing.** A register that captured one cycle late, or that read its own pre-edge value, would end a copy holding a stale byte.
- **Self-capture.** A register that is enabled and stored at once must OR its own value with the external value. A design that picked one bus source would lose bits.
- **Ignored external data.** External data with the valid flag low must not show up anywhere. A missing gate would leak it onto the bus and into strobed registers.
- **Multiple strobes.** With several strobes high on one edge, every strobed register must capture the same value.
- **Random traffic.** Constrained random cycles compare the bus against a bench model. A driver that overrides instead of OR-ing would clear bits that another source holds high.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned DEF_NREG  = 3;
  localparam int unsigned DEF_WIDTH = 8;

  // one bus lane contribution: a data bit passes only while its enable is high
  function automatic logic lane_gate(input logic d, input logic en);
    return d & en;
  endfunction

  // wired-OR merge of one bit into an accumulating lane
  function automatic logic lane_merge(input logic acc, input logic d);
    return acc | d;
  endfunction
endpackage

// File: rtl/rb_cell.sv
module rb_cell
  import regbank_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             store,
  input  logic             enable,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] drive_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (store) q <= bus_in;
  end

  always_comb begin
    for (int b = 0; b < WIDTH; b++) drive_o[b] = lane_gate(q[b], enable);
  end

  assign q_o = q;
endmodule

// File: rtl/rb_resolve.sv
module rb_resolve
  import regbank_pkg::*;
#(
  parameter int unsigned NREG  = DEF_NREG,
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic [NREG*WIDTH-1:0] drives_i,
  input  logic [WIDTH-1:0]      ext_data_i,
  input  logic                  ext_valid_i,
  output logic [WIDTH-1:0]      bus_o
);
  always_comb begin
    for (int b = 0; b < WIDTH; b++) begin
      bus_o[b] = lane_gate(ext_data_i[b], ext_valid_i);
      for (int k = 0; k < NREG; k++)
        bus_o[b] = lane_merge(bus_o[b], drives_i[k*WIDTH + b]);
    end
  end
endmodule

// File: rtl/shared_bus_regbank.sv
module shared_bus_regbank
  import regbank_pkg::*;
#(
  parameter int unsigned NREG  = DEF_NREG,
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NREG-1:0]  store_i,
  input  logic [NREG-1:0]  enable_i,
  input  logic [WIDTH-1:0] ext_data_i,
  input  logic             ext_valid_i,
  output logic [WIDTH-1:0] bus_o
);
  localparam int unsigned FLATW = NREG * WIDTH;

  // named internal wires, visible to the bound checker
  logic [FLATW-1:0] q_flat;
  logic [FLATW-1:0] drive_flat;
  logic [WIDTH-1:0] bus_w;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    rb_cell #(.WIDTH(WIDTH)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .store   (store_i[k]),
      .enable  (enable_i[k]),
      .bus_in  (bus_w),
      .q_o     (q_flat[k*WIDTH +: WIDTH]),
      .drive_o (drive_flat[k*WIDTH +: WIDTH])
    );
  end

  rb_resolve #(.NREG(NREG), .WIDTH(WIDTH)) u_resolve (
    .drives_i    (drive_flat),
    .ext_data_i  (ext_data_i),
    .ext_valid_i (ext_valid_i),
    .bus_o       (bus_w)
  );

  assign bus_o = bus_w;
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int unsigned NREG  = 3,
  parameter int unsigned WIDTH = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NREG-1:0]       store_i,
  input logic [NREG-1:0]       enable_i,
  input logic                  ext_valid_i,
  input logic [WIDTH-1:0]      bus_o,
  input logic [NREG*WIDTH-1:0] q_flat,
  input logic [NREG*WIDTH-1:0] drive_flat
);
  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk) rst_seen_q <= rst;

  // R1: the edge after a reset edge shows a cleared bank
  always_ff @(posedge clk) begin
    if (rst_seen_q) p_reset_clear_r1: assert (q_flat == '0);
  end

  for (genvar k = 0; k < NREG; k++) begin : g_chk
    p_store_r2: assert property (@(posedge clk) disable iff (rst)
      store_i[k] |=> q_flat[k*WIDTH +: WIDTH] == $past(bus_o));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !store_i[k] |=> $stable(q_flat[k*WIDTH +: WIDTH]));

    p_gate_zero_r4: assert property (@(posedge clk) disable iff (rst)
      !enable_i[k] |-> drive_flat[k*WIDTH +: WIDTH] == '0);

    p_or_keeps_ones_r5: assert property (@(posedge clk) disable iff (rst)
      (drive_flat[k*WIDTH +: WIDTH] & ~bus_o) == '0);
  end

  p_idle_bus_r7: assert property (@(posedge clk) disable iff (rst)
    (!ext_valid_i && enable_i == '0) |-> bus_o == '0);
endmodule

bind shared_bus_regbank rb_checker #(.NREG(NREG), .WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .store_i     (store_i),
  .enable_i    (enable_i),
  .ext_valid_i (ext_valid_i),
  .bus_o       (bus_o),
  .q_flat      (q_flat),
  .drive_flat  (drive_flat)
);

// File: tb/sim_shared_bus_regbank.sv
`timescale 1ns/1ps
module sim_shared_bus_regbank;
  localparam int N = 3;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] st = '0, oe = '0;
  logic [W-1:0] ed = '0;
  logic ev = 1'b0;
  logic [W-1:0] bus;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [W-1:0] model [N];

  always #4 clk = ~clk;  // 125 MHz

  shared_bus_regbank #(.NREG(N), .WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .store_i(st), .enable_i(oe),
    .ext_data_i(ed), .ext_valid_i(ev), .bus_o(bus));

  function automatic logic [W-1:0] exp_bus(logic [N-1:0] en, logic [W-1:0] d, logic v);
    logic [W-1:0] r = v ? d : '0;
    for (int k = 0; k < N; k++) if (en[k]) r |= model[k];
    return r;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // drive at falling edge, check bus mid-low phase, update model at rising edge
  task automatic tick(logic [N-1:0] s, logic [N-1:0] e, logic [W-1:0] d, logic v, string tag);
    logic [W-1:0] eb;
    @(negedge clk);
    st = s; oe = e; ed = d; ev = v;
    #2;
    eb = exp_bus(e, d, v);
    check(tag, bus, eb);
    @(posedge clk);
    for (int k = 0; k < N; k++) if (s[k]) model[k] = eb;
  endtask

  task automatic read_reg(int k, logic [W-1:0] expv, string tag);
    @(negedge clk);
    st = '0; oe = N'(1) << k; ev = 1'b0; ed = 8'hFF;
    #2;
    check(tag, bus, expv);
  endtask

  initial begin
    for (int k = 0; k < N; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    for (int k = 0; k < N; k++) read_reg(k, 8'h00, "R1 reset value");
    // R4 idle bus
    tick('0, '0, 8'h00, 1'b0, "R4 idle bus zero");
    // R7 invalid external data ignored
    tick('0, '0, 8'hA5, 1'b0, "R7 invalid ext data off bus");
    tick(3'b111, '0, 8'hFF, 1'b0, "R7 store with invalid ext");
    for (int k = 0; k < N; k++) read_reg(k, 8'h00, "R7 regs stay zero");

    // R2 load via external driver
    tick(3'b001, '0, 8'h5A, 1'b1, "R2 load bus");
    tick('0, '0, 8'h00, 1'b0, "R2 release");
    read_reg(0, 8'h5A, "R2 reg0 captured");
    // R3 strobe low: bus changes ignored
    tick('0, '0, 8'hC3, 1'b1, "R3 bus busy");
    read_reg(0, 8'h5A, "R3 reg0 held");
    read_reg(1, 8'h00, "R3 reg1 held");

    // R6 copy reg0 -> reg2
    tick('0, 3'b001, 8'h00, 1'b0, "R6 source enabled");
    tick(3'b100, 3'b001, 8'h00, 1'b0, "R6 dest strobe");
    tick('0, 3'b001, 8'h00, 1'b0, "R6 strobe dropped");
    tick('0, '0, 8'h00, 1'b0, "R6 bus back to zero");
    read_reg(2, 8'h5A, "R6 dest holds source");
    read_reg(1, 8'h00, "R6 other untouched");

    // R5 wired-OR of two registers plus external
    tick('0, 3'b101, 8'h81, 1'b1, "R5 OR of sources");
    @(negedge clk); #2; check("R5 OR value", bus, 8'hDB);

    // R9 self capture: reg0 enabled and strobed with ext 0x81
    tick(3'b001, 3'b001, 8'h81, 1'b1, "R9 self bus");
    read_reg(0, 8'hDB, "R9 self OR captured");

    // R8 multiple strobes
    tick(3'b111, '0, 8'h3C, 1'b1, "R8 broadcast");
    for (int k = 0; k < N; k++) read_reg(k, 8'h3C, "R8 all captured");

    // random traffic
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] rs, re;
      rs = N'($urandom_range(0, 7));
      if ($urandom_range(0, 2) != 0) rs = '0;
      re = N'($urandom_range(0, 7));
      tick(rs, re, 8'($urandom), 1'($urandom_range(0, 1)), "R5 random bus");
    end
    for (int k = 0; k < N; k++) read_reg(k, model[k], "R2 random final contents");

    // R1 reset again
    @(negedge clk); rst = 1'b1; st = '0; oe = '0; ev = 1'b0;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < N; k++) read_reg(k, 8'h00, "R1 reset clears");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule